// File: doc/BRIEF.md
# CMOS Real-Time Clock

This block is a byte-wide real-time clock with 128 bytes of non-volatile-style configuration storage. Software reaches it through two port addresses. Port 0 selects a byte index and port 1 reads or writes the selected byte. The time of day and the calendar are kept in BCD. Two management-loaded cycle counts set the timebase: one gives the clock cycles per second, the other the clock cycles per periodic-interrupt interval. The time therefore advances at a rate set by the host system, with no fixed crystal divider.

A 32-bit management write port preloads every storage byte from the low byte of its data word. It also loads both divisors, so a system controller can bring the clock to a known image before software runs. Three status events can raise the interrupt line: the periodic tick, the end of a one-second update, and an alarm match. Each event has its own enable bit.

The strobes are single-cycle and carry no back-pressure. The block accepts an access in every cycle that a strobe is high. There is no ready signal, so a caller must never hold a strobe for longer than the one access it means.

Top module: `cmos_rtc`

## Requirements
- R1: A write to port address 0 latches bits 6:0 of the write data as the byte index. A read of port 0 returns {0, index}. A read or write on port address 1 accesses the byte at the latched index. Read data appears on io_rdata in the cycle after the read strobe and holds until the next read.
- R2: A management write to addresses 0 to 127 loads that byte from mgmt_wdata[7:0]. The upper data bits are ignored.
- R3: A management write to address 128 loads a 27-bit cycles-per-second divisor. A write to address 129 loads a 13-bit cycles-per-periodic-interval divisor. Each load restarts its counter, and a tick follows every N cycles after it. N = 0 stops the ticks.
- R4: On each one-second tick, the time fields advance in BCD. Seconds sit at byte 0, minutes at byte 2 and hours at byte 4 (24-hour form). Seconds wrap 59 to 00 and minutes wrap 59 to 00, each carrying into the next field. Hours wrap 23 to 00 and carry into day-of-week (byte 6, counting 1 to 7 and wrapping 7 to 1) and into the date.
- R5: The date sits at byte 7 and rolls to 01 after the last day of the month. February has 29 days when the BCD year is divisible by 4 and 28 days otherwise. April, June, September and November have 30 days, and all other months have 31. The month sits at byte 8 and wraps 12 to 01. The year sits at byte 9 and wraps 99 to 00.
- R6: While bit 7 of control register B (byte 11) is set, second ticks leave all time bytes unchanged and raise no update flag.
- R7: After reset, register A (byte 10) reads 0x26, register B reads 0x02, register C (byte 12) reads 0x00, register D (byte 13) reads 0x80, and irq is low. Bit 7 of A always reads 0, and bits 6:0 of A are writable.
- R8: Register C is read-only, and a read of C clears its flags. An event arriving in the same cycle as the read still sets its flag. Register D is read-only and always reads 0x80. Writes to C or D from either port have no effect.
- R9: A periodic tick sets C bit 6, but only when A[3:0] is nonzero.
- R10: A one-second update sets C bit 4. If the updated seconds, minutes and hours equal the alarm bytes (bytes 1, 3 and 5), the update also sets C bit 5.
- R11: C bit 7 and irq are high exactly when a flag in C[6:4] is set together with the enable in the same position of B[6:4]. irq stays low whenever B[6:4] is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq | output | 1 | Interrupt request |
| io_addr | input | 1 | Port select: 0 index, 1 data |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, valid the cycle after io_rd |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| mgmt_addr | input | 8 | Management address (0-127 bytes, 128/129 divisors) |
| mgmt_wr | input | 1 | Management write strobe |
| mgmt_wdata | input | 32 | Management write data |

## Verification
A wrong carry decision in the time counters stays hidden until the bytes are read back. It then shows as a wrong BCD value on the first read after the tick, so the bench reads every time byte after a rollover. A flag that is set or cleared wrongly shows on irq within one cycle whenever its enable is set. It also shows in the value of the next register C read. The bench checks both, and it reads C twice to show that the first read cleared it. A divisor counter that is off by a cycle changes the number of ticks in a fixed window, and that becomes visible as a seconds value that is off by one.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int TIME_BYTES = 10;
  localparam int IX_SEC  = 0;
  localparam int IX_ASEC = 1;
  localparam int IX_MIN  = 2;
  localparam int IX_AMIN = 3;
  localparam int IX_HR   = 4;
  localparam int IX_AHR  = 5;
  localparam int IX_DOW  = 6;
  localparam int IX_DATE = 7;
  localparam int IX_MON  = 8;
  localparam int IX_YR   = 9;
  localparam int IX_CTLA = 10;
  localparam int IX_CTLB = 11;
  localparam int IX_STAT = 12;
  localparam int IX_VALID = 13;

  localparam logic [6:0] CTLA_RST = 7'h26;
  localparam logic [7:0] CTLB_RST = 8'h02;
  localparam logic [7:0] VALID_VAL = 8'h80;

  typedef logic [7:0] byte_t;

  function automatic byte_t bcd_inc(input byte_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic byte_t month_end(input byte_t mon, input byte_t yr);
    logic [7:0] ybin;
    ybin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
    case (mon)
      8'h02:                      return (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         tick
);
  logic [W-1:0] lim_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else if (ld) begin
      lim_q <= ld_val;
      cnt_q <= '0;
    end else if (lim_q != '0) begin
      if (cnt_q == lim_q - W'(1)) cnt_q <= '0;
      else cnt_q <= cnt_q + W'(1);
    end
  end

  assign tick = !ld && (lim_q != '0) && (cnt_q == lim_q - W'(1));

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lim_q > W'(1)) |=> !tick); // R3
endmodule

// File: rtl/rtc_time.sv
module rtc_time
  import rtc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sec_tick,
  input  logic                          hold,
  input  logic                          wr_en,
  input  logic [3:0]                    wr_idx,
  input  logic [7:0]                    wr_data,
  output logic [TIME_BYTES-1:0][7:0]    tbytes,
  output logic                          upd,
  output logic                          alarm_hit
);
  logic [TIME_BYTES-1:0][7:0] r_q, tv, r_n;

  always_comb begin
    tv  = r_q;
    upd = 1'b0;
    if (sec_tick && !hold) begin
      upd = 1'b1;
      if (r_q[IX_SEC] != 8'h59) tv[IX_SEC] = bcd_inc(r_q[IX_SEC]);
      else begin
        tv[IX_SEC] = 8'h00;
        if (r_q[IX_MIN] != 8'h59) tv[IX_MIN] = bcd_inc(r_q[IX_MIN]);
        else begin
          tv[IX_MIN] = 8'h00;
          if (r_q[IX_HR] != 8'h23) tv[IX_HR] = bcd_inc(r_q[IX_HR]);
          else begin
            tv[IX_HR]  = 8'h00;
            tv[IX_DOW] = (r_q[IX_DOW] >= 8'h07) ? 8'h01 : r_q[IX_DOW] + 8'h01;
            if (r_q[IX_DATE] < month_end(r_q[IX_MON], r_q[IX_YR]))
              tv[IX_DATE] = bcd_inc(r_q[IX_DATE]);
            else begin
              tv[IX_DATE] = 8'h01;
              if (r_q[IX_MON] < 8'h12) tv[IX_MON] = bcd_inc(r_q[IX_MON]);
              else begin
                tv[IX_MON] = 8'h01;
                tv[IX_YR]  = (r_q[IX_YR] == 8'h99) ? 8'h00 : bcd_inc(r_q[IX_YR]);
              end
            end
          end
        end
      end
    end
    r_n = tv;
    if (wr_en && (wr_idx < 4'(TIME_BYTES))) r_n[wr_idx] = wr_data;
  end

  assign alarm_hit = upd && (tv[IX_SEC] == r_q[IX_ASEC]) &&
                     (tv[IX_MIN] == r_q[IX_AMIN]) && (tv[IX_HR] == r_q[IX_AHR]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_q <= '0;
    else r_q <= r_n;
  end

  assign tbytes = r_q;

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !hold && !wr_en && r_q[IX_SEC] == 8'h59) |=> (r_q[IX_SEC] == 8'h00)); // R4
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wr_en) |=> $stable(r_q)); // R6
endmodule

// File: rtl/rtc_cmos.sv
module rtc_cmos #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  AST_STORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata))); // R2
endmodule

// File: rtl/cmos_rtc.sv
module cmos_rtc
  import rtc_pkg::*;
#(
  parameter int SEC_W = 27,
  parameter int PER_W = 13,
  parameter int DEPTH = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        irq,
  input  logic        io_addr,
  input  logic        io_rd,
  output logic [7:0]  io_rdata,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  input  logic [7:0]  mgmt_addr,
  input  logic        mgmt_wr,
  input  logic [31:0] mgmt_wdata
);
  localparam int IW = $clog2(DEPTH);

  logic [IW-1:0] idx_q;
  logic          mg_byte, mg_sdiv, mg_pdiv, io_dwr;
  logic          w_en;
  logic [IW-1:0] w_idx;
  logic [7:0]    w_dat;
  logic          sec_tick, per_tick, upd, alarm_hit;
  logic [TIME_BYTES-1:0][7:0] tbytes;
  logic [6:0]    reg_a;
  logic [7:0]    reg_b;
  logic [2:0]    flags_q, set_v;
  logic          c_rd, irqf;
  logic [7:0]    store_rd, rd_val;
  logic          unused_bits;

  assign unused_bits = ^{mgmt_wdata[31:SEC_W], io_wdata[7]};

  assign mg_byte = mgmt_wr && (mgmt_addr < 8'(DEPTH));
  assign mg_sdiv = mgmt_wr && (mgmt_addr == 8'(DEPTH));
  assign mg_pdiv = mgmt_wr && (mgmt_addr == 8'(DEPTH + 1));
  assign io_dwr  = io_wr && io_addr;

  assign w_en  = mg_byte || io_dwr;
  assign w_idx = mg_byte ? mgmt_addr[IW-1:0] : idx_q;
  assign w_dat = mg_byte ? mgmt_wdata[7:0] : io_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (io_wr && !io_addr) idx_q <= io_wdata[IW-1:0];
  end

  rtc_divider #(.W(SEC_W)) u_sec_div (
    .clk(clk), .rst_n(rst_n), .ld(mg_sdiv),
    .ld_val(mgmt_wdata[SEC_W-1:0]), .tick(sec_tick)
  );

  rtc_divider #(.W(PER_W)) u_per_div (
    .clk(clk), .rst_n(rst_n), .ld(mg_pdiv),
    .ld_val(mgmt_wdata[PER_W-1:0]), .tick(per_tick)
  );

  rtc_time u_time (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .hold(reg_b[7]),
    .wr_en(w_en && (w_idx < IW'(TIME_BYTES))), .wr_idx(w_idx[3:0]),
    .wr_data(w_dat), .tbytes(tbytes), .upd(upd), .alarm_hit(alarm_hit)
  );

  rtc_cmos #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(w_en && (w_idx > IW'(IX_VALID))), .waddr(w_idx), .wdata(w_dat),
    .raddr(idx_q), .rdata(store_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a <= CTLA_RST;
      reg_b <= CTLB_RST;
    end else begin
      if (w_en && w_idx == IW'(IX_CTLA)) reg_a <= w_dat[6:0];
      if (w_en && w_idx == IW'(IX_CTLB)) reg_b <= w_dat;
    end
  end

  assign set_v = {per_tick && (reg_a[3:0] != 4'd0), alarm_hit, upd};
  assign c_rd  = io_rd && io_addr && (idx_q == IW'(IX_STAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else flags_q <= (c_rd ? 3'b000 : flags_q) | set_v;
  end

  assign irqf = |(flags_q & reg_b[6:4]);
  assign irq  = irqf;

  always_comb begin
    if (idx_q < IW'(TIME_BYTES))        rd_val = tbytes[idx_q[3:0]];
    else if (idx_q == IW'(IX_CTLA))     rd_val = {1'b0, reg_a};
    else if (idx_q == IW'(IX_CTLB))     rd_val = reg_b;
    else if (idx_q == IW'(IX_STAT))     rd_val = {irqf, flags_q, 4'd0};
    else if (idx_q == IW'(IX_VALID))    rd_val = VALID_VAL;
    else                                rd_val = store_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) io_rdata <= '0;
    else if (io_rd) io_rdata <= io_addr ? rd_val : 8'(idx_q);
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_b[6:4] == 3'b000) |-> !irq); // R11
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && set_v == 3'b000) |=> (flags_q == 3'b000)); // R8
  AST_VALID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr && idx_q == IW'(IX_VALID)) |=> (io_rdata == 8'h80)); // R8
  AST_INDEX_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_addr) |=> (io_rdata[7] == 1'b0)); // R1
endmodule

// File: tb/tb_cmos_rtc.sv
module tb_cmos_rtc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq;
  logic        io_addr = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_rdata, io_wdata = '0;
  logic [7:0]  mgmt_addr = '0;
  logic        mgmt_wr = 1'b0;
  logic [31:0] mgmt_wdata = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_q = 1'b0;

  always #2.5 clk = ~clk;

  cmos_rtc dut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .io_addr(io_addr), .io_rd(io_rd),
    .io_rdata(io_rdata), .io_wr(io_wr), .io_wdata(io_wdata),
    .mgmt_addr(mgmt_addr), .mgmt_wr(mgmt_wr), .mgmt_wdata(mgmt_wdata)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard the cycle after each read strobe
  always @(posedge clk) rd_q <= io_rd;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R1: unexpected read data actual %02h expected none", io_rdata);
      end else begin
        check(io_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic mg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); mgmt_wr = 1'b1; mgmt_addr = a; mgmt_wdata = d;
    @(negedge clk); mgmt_wr = 1'b0;
  endtask

  task automatic io_write(input logic a, input logic [7:0] d);
    @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk); io_rd = 1'b1; io_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic rd_byte(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    io_write(1'b0, idx);
    io_read(1'b1, exp, tag);
  endtask

  task automatic wr_byte(input logic [7:0] idx, input logic [7:0] d);
    io_write(1'b0, idx);
    io_write(1'b1, d);
  endtask

  task automatic load_time(input logic [7:0] hr, mi, se, dw, dt, mo, yr);
    mg_wr(8'd0, {24'd0, se}); mg_wr(8'd2, {24'd0, mi}); mg_wr(8'd4, {24'd0, hr});
    mg_wr(8'd6, {24'd0, dw}); mg_wr(8'd7, {24'd0, dt}); mg_wr(8'd8, {24'd0, mo});
    mg_wr(8'd9, {24'd0, yr});
  endtask

  // exactly one second tick: divisor 100, 150 cycles, then stop
  task automatic one_second();
    mg_wr(8'd128, 32'd100);
    repeat (150) @(negedge clk);
    mg_wr(8'd128, 32'd0);
  endtask

  task automatic check_date(input logic [7:0] hr, mi, se, dw, dt, mo, yr, input string tag);
    rd_byte(8'd0, se, tag); rd_byte(8'd2, mi, tag); rd_byte(8'd4, hr, tag);
    rd_byte(8'd6, dw, tag); rd_byte(8'd7, dt, tag); rd_byte(8'd8, mo, tag);
    rd_byte(8'd9, yr, tag);
  endtask

  initial begin
    #(5ns * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check({7'd0, irq}, 8'd0, "R7 irq after reset");
    rd_byte(8'd10, 8'h26, "R7 reg A reset");
    rd_byte(8'd11, 8'h02, "R7 reg B reset");
    rd_byte(8'd12, 8'h00, "R7 reg C reset");
    rd_byte(8'd13, 8'h80, "R7 reg D reset");
    // R1 index readback
    io_write(1'b0, 8'hC5);
    io_read(1'b0, 8'h45, "R1 index readback");
    // R2 management preload, low byte only
    mg_wr(8'h20, 32'h1234_565A);
    rd_byte(8'h20, 8'h5A, "R2 preload low byte");
    // R1 data port write then read
    wr_byte(8'h7F, 8'hC3);
    rd_byte(8'h7F, 8'hC3, "R1 data port write/read");
    // R4 R5 full carry, non-leap Feb
    load_time(8'h23, 8'h59, 8'h59, 8'h07, 8'h28, 8'h02, 8'h23);
    one_second();
    check_date(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h03, 8'h23, "R4 R5 Feb non-leap rollover");
    // R10 update and alarm (alarm bytes are 00:00:00), R8 clear on read
    rd_byte(8'd12, 8'h30, "R10 update+alarm flags");
    rd_byte(8'd12, 8'h00, "R8 C cleared by read");
    // R5 leap year
    load_time(8'h23, 8'h59, 8'h59, 8'h03, 8'h28, 8'h02, 8'h24);
    one_second();
    check_date(8'h00, 8'h00, 8'h00, 8'h04, 8'h29, 8'h02, 8'h24, "R5 leap Feb");
    rd_byte(8'd12, 8'h30, "R10 flags leap");
    // R5 year wrap
    load_time(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
    one_second();
    check_date(8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00, "R5 year wrap");
    rd_byte(8'd12, 8'h30, "R10 flags year");
    // R5 30-day month
    load_time(8'h23, 8'h59, 8'h59, 8'h02, 8'h30, 8'h04, 8'h10);
    one_second();
    check_date(8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h05, 8'h10, "R5 April end");
    rd_byte(8'd12, 8'h30, "R10 flags April");
    // R4 plain carry, no alarm match
    load_time(8'h10, 8'h15, 8'h59, 8'h02, 8'h30, 8'h04, 8'h10);
    one_second();
    check_date(8'h10, 8'h16, 8'h00, 8'h02, 8'h30, 8'h04, 8'h10, "R4 minute carry");
    rd_byte(8'd12, 8'h10, "R10 update only");
    // R6 halt
    wr_byte(8'd11, 8'h82);
    mg_wr(8'd0, 32'h10);
    one_second();
    rd_byte(8'd0, 8'h10, "R6 halted seconds");
    rd_byte(8'd12, 8'h00, "R6 no update flag");
    // R10 R11 alarm interrupt
    wr_byte(8'd11, 8'h22);
    mg_wr(8'd1, 32'h05); mg_wr(8'd3, 32'h00); mg_wr(8'd5, 32'h00);
    load_time(8'h00, 8'h00, 8'h04, 8'h01, 8'h01, 8'h01, 8'h01);
    one_second();
    check({7'd0, irq}, 8'd1, "R11 alarm irq");
    rd_byte(8'd12, 8'hB0, "R10 R11 alarm C value");
    check({7'd0, irq}, 8'd0, "R8 irq drops after C read");
    // R9 R11 periodic interrupt
    wr_byte(8'd11, 8'h42);
    mg_wr(8'd129, 32'd10);
    repeat (15) @(negedge clk);
    mg_wr(8'd129, 32'd0);
    check({7'd0, irq}, 8'd1, "R11 periodic irq");
    rd_byte(8'd12, 8'hC0, "R9 periodic C value");
    check({7'd0, irq}, 8'd0, "R8 periodic irq cleared");
    // R11 masked: no irq while enables clear
    wr_byte(8'd11, 8'h02);
    mg_wr(8'd129, 32'd10);
    begin
      int hi = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (irq) hi++;
      end
      check(8'(hi), 8'd0, "R11 masked irq cycles");
    end
    mg_wr(8'd129, 32'd0);
    rd_byte(8'd12, 8'h40, "R9 R11 masked flag no IRQF");
    // R9 rate field zero suppresses periodic flag
    wr_byte(8'd10, 8'h20);
    mg_wr(8'd129, 32'd10);
    repeat (30) @(negedge clk);
    mg_wr(8'd129, 32'd0);
    rd_byte(8'd12, 8'h00, "R9 rate zero");
    // R7 A bit7 reads zero
    wr_byte(8'd10, 8'hA6);
    rd_byte(8'd10, 8'h26, "R7 A bit7");
    // R8 writes to C and D ignored
    wr_byte(8'd12, 8'hFF);
    wr_byte(8'd13, 8'h00);
    mg_wr(8'd13, 32'h00);
    rd_byte(8'd12, 8'h00, "R8 C write ignored");
    rd_byte(8'd13, 8'h80, "R8 D write ignored");
    // R3 second divisor count: 5 ticks in 5*20 + 10 cycles
    mg_wr(8'd0, 32'h00);
    mg_wr(8'd128, 32'd20);
    repeat (109) @(negedge clk);
    mg_wr(8'd128, 32'd0);
    rd_byte(8'd0, 8'h05, "R3 tick count");
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R1: actual %0d pending reads expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end
endmodule